// File: doc/BRIEF.md
# Banked Subtract Execution Unit

This unit carries out two 8-bit subtract instructions for a small accumulator-style processor datapath. It holds the working register (W), a bank pointer and a banked byte memory. One form subtracts W from an 8-bit literal held in the instruction. The other subtracts W from a byte in data memory and sends the result either to W or back to that byte. Every instruction also writes five status flags. Carry is a not-borrow: it is 1 when no borrow occurs.

A strobe starts an instruction. The unit then steps through four fixed phases: decode, operand read, compute and write-back. It marks the end with a one-cycle completion pulse. Nothing is committed before the write-back phase. Two load ports preset the bank pointer and memory bytes while the unit is idle. They stand in for the rest of the processor, which is outside this block.

Top module: `sub_exec_unit`

## Requirements
- R1: While reset is high and after it is released, W, the status flags, the bank pointer, result_o, wr_addr_o, busy_o, done_o, illegal_o and mem_wr_o are all zero.
- R2: An instruction word with bits [15:8] = 0x08 writes (bits [7:0] − W) mod 256 into W.
- R3: An instruction word with bits [15:10] = 6'b010111 computes (memory byte − W) mod 256. When bit 9 is 0 the result goes to W and memory is unchanged. When bit 9 is 1 the result goes back to the same memory byte and W is unchanged.
- R4: For the memory form, bits [7:0] give the byte offset. When bit 8 is 1, the bank is the bank pointer. When bit 8 is 0, the bank pointer is ignored: offsets 0x00–0x7F use bank 0 and offsets 0x80–0xFF use the highest bank (15). The byte address is bank×256 + offset.
- R5: status_o bit 0 (carry) is 1 exactly when the minuend ≥ W as unsigned 8-bit values. Bit 1 (digit carry) is 1 exactly when the minuend's low nibble ≥ W's low nibble.
- R6: status_o bit 2 is 1 when the 8-bit result is zero, and bit 4 equals result bit 7. Bit 3 (overflow) is 1 when the signed difference of minuend and W lies outside −128..127.
- R7: start_i is accepted only while busy_o is low. busy_o is high for the four cycles after acceptance. done_o is then high for exactly one cycle, and a start_i pulse while busy_o is high starts nothing.
- R8: W and status_o keep their old values while busy_o is high. They change only in the cycle done_o rises.
- R9: Any other instruction word leaves W, status_o, result_o and memory unchanged, and raises illegal_o in the same cycle as done_o.
- R10: With done_o for a valid instruction, result_o carries the 8-bit result. mem_wr_o is 1 exactly when the result was written to memory, and wr_addr_o then gives its byte address.
- R11: bsr_ld_i and mem_ld_i take effect only while busy_o is low and start_i is low. A memory load while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for instr_i |
| instr_i | input | 16 | Instruction word |
| bsr_ld_i | input | 1 | Load the bank pointer from bsr_i |
| bsr_i | input | 4 | Bank pointer value |
| mem_ld_i | input | 1 | Preset one memory byte |
| mem_addr_i | input | 12 | Byte address for the preset |
| mem_data_i | input | 8 | Byte value for the preset |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Completed word was not a subtract |
| w_o | output | 8 | Working register |
| status_o | output | 5 | {N, OV, Z, DC, C} |
| result_o | output | 8 | Last committed result |
| mem_wr_o | output | 1 | Last result went to memory |
| wr_addr_o | output | 12 | Memory byte address written |

## Verification
The literal form is run with the small minuend 2 against W values of 1, 2 and 3. These separate the positive, zero and wrapped-negative outcomes and their carry and sign bits. Pairs that cross the signed boundary, such as 0x80−0x01 and 0x7F−0x80, separate overflow from carry. Nibble-crossing pairs separate digit carry from carry. The memory form is run at low and high access-bank offsets and through the bank pointer with a distinct byte stored at each candidate address, so a wrong bank or a misread bit 8 produces a wrong result. Write-backs are read back by a later instruction. A long mixed run compares every cycle against a behavioural model. Near-miss opcodes, a start pulse while busy and a preset while busy show that nothing is touched when it should not be.

// File: rtl/sub_pkg.sv
package sub_pkg;
  localparam int DW = 8;
  localparam int IW = 16;

  localparam logic [7:0] OPC_LIT = 8'h08;
  localparam logic [5:0] OPC_MEM = 6'b010111;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEC,
    PH_RD,
    PH_PROC,
    PH_WR
  } phase_t;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

  typedef struct packed {
    logic          lit;
    logic          mem_op;
    logic          to_mem;
    logic [DW-1:0] byte_f;
  } dec_t;
endpackage

// File: rtl/sub_decode.sv
module sub_decode
  import sub_pkg::*;
#(
  parameter int BANK_BITS = 4,
  localparam int AW = BANK_BITS + DW
) (
  input  logic [IW-1:0]        instr_i,
  input  logic [BANK_BITS-1:0] bsr_i,
  output dec_t                 dec_o,
  output logic [AW-1:0]        addr_o
);
  logic                 fixed_bank;
  logic [BANK_BITS-1:0] bank;

  always_comb begin
    dec_o.lit    = (instr_i[15:8] == OPC_LIT);
    dec_o.mem_op = (instr_i[15:10] == OPC_MEM);
    dec_o.to_mem = dec_o.mem_op & instr_i[9];
    dec_o.byte_f = instr_i[7:0];
    fixed_bank   = ~instr_i[8];
    bank         = fixed_bank ? {BANK_BITS{instr_i[7]}} : bsr_i;
    addr_o       = {bank, instr_i[7:0]};
  end
endmodule

// File: rtl/sub_alu.sv
module sub_alu
  import sub_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] w_i,
  output logic [DW-1:0] res_o,
  output flags_t        flg_o
);
  logic [DW:0] full;
  logic [4:0]  low;

  always_comb begin
    full      = {1'b0, a_i} + {1'b0, ~w_i} + {{DW{1'b0}}, 1'b1};
    low       = {1'b0, a_i[3:0]} + {1'b0, ~w_i[3:0]} + 5'd1;
    res_o     = full[DW-1:0];
    flg_o.c   = full[DW];
    flg_o.dc  = low[4];
    flg_o.z   = (full[DW-1:0] == '0);
    flg_o.n   = full[DW-1];
    flg_o.ov  = (a_i[DW-1] ^ w_i[DW-1]) & (full[DW-1] ^ a_i[DW-1]);
  end
endmodule

// File: rtl/sub_bankram.sv
module sub_bankram #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[waddr_i] <= wdata_i;
    rdata_o <= store[raddr_i];
  end
endmodule

// File: rtl/sub_exec_unit.sv
module sub_exec_unit
  import sub_pkg::*;
#(
  parameter int BANK_BITS = 4,
  localparam int AW = BANK_BITS + DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [IW-1:0]        instr_i,
  input  logic                 bsr_ld_i,
  input  logic [BANK_BITS-1:0] bsr_i,
  input  logic                 mem_ld_i,
  input  logic [AW-1:0]        mem_addr_i,
  input  logic [DW-1:0]        mem_data_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 illegal_o,
  output logic [DW-1:0]        w_o,
  output logic [4:0]           status_o,
  output logic [DW-1:0]        result_o,
  output logic                 mem_wr_o,
  output logic [AW-1:0]        wr_addr_o
);
  phase_t               phase_q;
  logic [IW-1:0]        instr_q;
  logic [BANK_BITS-1:0] bsr_q;
  dec_t                 dec_w, dec_q;
  logic [AW-1:0]        addr_w, addr_q;
  logic [DW-1:0]        w_q, res_q, rd_data, opa, alu_res;
  flags_t               alu_flg, flg_q, status_q;
  logic                 idle_ld;
  logic                 ram_we;
  logic [AW-1:0]        ram_waddr;
  logic [DW-1:0]        ram_wdata;

  sub_decode #(.BANK_BITS(BANK_BITS)) u_dec (
    .instr_i (instr_q),
    .bsr_i   (bsr_q),
    .dec_o   (dec_w),
    .addr_o  (addr_w)
  );

  assign opa = dec_q.lit ? dec_q.byte_f : rd_data;

  sub_alu u_alu (
    .a_i   (opa),
    .w_i   (w_q),
    .res_o (alu_res),
    .flg_o (alu_flg)
  );

  assign idle_ld = (phase_q == PH_IDLE) && !start_i;

  always_comb begin
    if (phase_q == PH_WR && dec_q.to_mem) begin
      ram_we    = 1'b1;
      ram_waddr = addr_q;
      ram_wdata = res_q;
    end else begin
      ram_we    = mem_ld_i && idle_ld;
      ram_waddr = mem_addr_i;
      ram_wdata = mem_data_i;
    end
  end

  sub_bankram #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (addr_q),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      instr_q   <= '0;
      bsr_q     <= '0;
      dec_q     <= '0;
      addr_q    <= '0;
      res_q     <= '0;
      flg_q     <= '0;
      w_q       <= '0;
      status_q  <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      mem_wr_o  <= 1'b0;
      wr_addr_o <= '0;
    end else begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      mem_wr_o  <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            instr_q <= instr_i;
            busy_o  <= 1'b1;
            phase_q <= PH_DEC;
          end else if (bsr_ld_i) begin
            bsr_q <= bsr_i;
          end
        end
        PH_DEC: begin
          dec_q   <= dec_w;
          addr_q  <= addr_w;
          phase_q <= PH_RD;
        end
        PH_RD: begin
          phase_q <= PH_PROC;
        end
        PH_PROC: begin
          res_q   <= alu_res;
          flg_q   <= alu_flg;
          phase_q <= PH_WR;
        end
        PH_WR: begin
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
          phase_q <= PH_IDLE;
          if (dec_q.lit || dec_q.mem_op) begin
            status_q <= flg_q;
            result_o <= res_q;
            if (!dec_q.to_mem) w_q <= res_q;
            mem_wr_o  <= dec_q.to_mem;
            if (dec_q.to_mem) wr_addr_o <= addr_q;
          end else begin
            illegal_o <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign w_o      = w_q;
  assign status_o = status_q;

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WR) |=> (done_o && !busy_o)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_W_HELD_EARLY: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_WR) |=> ($stable(w_q) && $stable(status_q))); // R8
  AST_ILLEGAL_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> ($stable(w_o) && $stable(status_o) && $stable(result_o) && !mem_wr_o)); // R9
  AST_CARRY_NOBORROW: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PROC) |-> (alu_flg.c == (opa >= w_q))); // R5
  AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PROC) |-> (alu_flg.z == (opa == w_q))); // R6
endmodule

// File: tb/sim_sub_exec_unit.sv
`timescale 1ns/1ps
module sim_sub_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        bsr_ld_i = 1'b0;
  logic [3:0]  bsr_i = '0;
  logic        mem_ld_i = 1'b0;
  logic [11:0] mem_addr_i = '0;
  logic [7:0]  mem_data_i = '0;
  logic        busy_o, done_o, illegal_o, mem_wr_o;
  logic [7:0]  w_o, result_o;
  logic [4:0]  status_o;
  logic [11:0] wr_addr_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int        mw = 0;
  int        mstat = 0;
  int        mres = 0;
  int        maddr = 0;
  int        mbsr = 0;
  int        mmem [int];

  always #5 clk = ~clk;

  sub_exec_unit u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i),
    .bsr_ld_i(bsr_ld_i), .bsr_i(bsr_i), .mem_ld_i(mem_ld_i),
    .mem_addr_i(mem_addr_i), .mem_data_i(mem_data_i),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .w_o(w_o),
    .status_o(status_o), .result_o(result_o), .mem_wr_o(mem_wr_o),
    .wr_addr_o(wr_addr_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_mem(input int addr, input int val);
    @(negedge clk);
    mem_ld_i = 1'b1; mem_addr_i = addr[11:0]; mem_data_i = val[7:0];
    @(negedge clk);
    mem_ld_i = 1'b0;
    mmem[addr] = val & 255;
  endtask

  task automatic load_bsr(input int v);
    @(negedge clk);
    bsr_ld_i = 1'b1; bsr_i = v[3:0];
    @(negedge clk);
    bsr_ld_i = 1'b0;
    mbsr = v & 15;
  endtask

  // inj: 1 = extra start while busy, 2 = memory preset while busy
  task automatic exec(input logic [15:0] ins, input int inj, input int inj_addr);
    int  a, w0, s0, r0, res, sd;
    bit  lit, mop, tomem, legal;
    int  addr;
    lit   = (ins[15:8] == 8'h08);
    mop   = (ins[15:10] == 6'b010111);
    legal = lit || mop;
    tomem = mop && ins[9];
    if (!ins[8]) addr = (ins[7] ? 15 * 256 : 0) + ins[7:0];
    else         addr = mbsr * 256 + ins[7:0];
    w0 = mw; s0 = mstat; r0 = mres;
    a  = lit ? ins[7:0] : (mmem.exists(addr) ? mmem[addr] : 0);
    @(negedge clk);
    start_i = 1'b1; instr_i = ins;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      chk("R7", "busy while running", busy_o, 1);
      chk("R7", "done early", done_o, 0);
      chk("R8", "W held while busy", w_o, w0);
      chk("R8", "status held while busy", status_o, s0);
      if (inj == 1 && i == 1) begin start_i = 1'b1; instr_i = 16'h08FF; end
      else if (inj == 2 && i == 1) begin
        mem_ld_i = 1'b1; mem_addr_i = inj_addr[11:0]; mem_data_i = 8'h77;
      end else begin start_i = 1'b0; mem_ld_i = 1'b0; end
    end
    @(negedge clk);
    start_i = 1'b0; mem_ld_i = 1'b0;
    if (legal) begin
      res = (a - mw) & 255;
      sd  = $signed(a[7:0]) - $signed(mw[7:0]);
      mstat = ((res >= 128) ? 16 : 0) | ((sd > 127 || sd < -128) ? 8 : 0)
            | ((res == 0) ? 4 : 0) | (((a & 15) >= (mw & 15)) ? 2 : 0)
            | ((a >= mw) ? 1 : 0);
      mres = res;
      if (tomem) begin mmem[addr] = res; maddr = addr; end
      else mw = res;
    end
    chk("R7", "done pulse", done_o, 1);
    chk("R7", "busy cleared", busy_o, 0);
    chk("R9", "illegal flag", illegal_o, legal ? 0 : 1);
    chk(lit ? "R2" : (mop ? "R3" : "R9"), "W after", w_o, mw);
    chk("R5", "C/DC", status_o[1:0], mstat & 3);
    chk("R6", "N/OV/Z", status_o[4:2], (mstat >> 2) & 7);
    chk("R10", "result", result_o, mres);
    chk("R10", "mem write flag", mem_wr_o, tomem ? 1 : 0);
    if (tomem) chk("R4", "write address", wr_addr_o, maddr);
    @(negedge clk);
    chk("R7", "single done", done_o, 0);
    chk("R7", "no restart", busy_o, 0);
  endtask

  task automatic set_w(input int v);
    exec({8'h08, 8'((v + mw) & 255)}, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "W reset", w_o, 0);
    chk("R1", "status reset", status_o, 0);
    chk("R1", "flags reset", {busy_o, done_o, illegal_o, mem_wr_o}, 0);
    chk("R1", "result reset", result_o, 0);
    chk("R1", "addr reset", wr_addr_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "W after release", w_o, 0);
    chk("R1", "busy after release", busy_o, 0);

    // R2 literal form: positive, zero, negative
    set_w(1); exec(16'h0802, 0, 0);
    set_w(2); exec(16'h0802, 0, 0);
    set_w(3); exec(16'h0802, 0, 0);
    chk("R2", "2-3 wraps", w_o, 8'hFF);
    chk("R5", "2-3 borrow", status_o[0], 0);
    chk("R6", "2-3 negative", status_o[4], 1);
    // R6 overflow, R5 nibble borrow
    set_w(8'h01); exec(16'h0880, 0, 0);
    chk("R6", "0x80-1 overflow", status_o[3], 1);
    set_w(8'h80); exec(16'h087F, 0, 0);
    chk("R6", "0x7F-0x80 overflow", status_o[3], 1);
    set_w(8'h0F); exec(16'h0810, 0, 0);
    chk("R5", "nibble borrow DC", status_o[1:0], 2'b01);

    // R4 bank selection: distinct bytes at each candidate address
    load_bsr(5);
    load_mem(16'h010, 8'h40); load_mem(16'h510, 8'h50); load_mem(16'hF10, 8'h60);
    load_mem(16'h090, 8'h41); load_mem(16'h590, 8'h51); load_mem(16'hF90, 8'h61);
    set_w(8'h01); exec(16'h5C10, 0, 0);
    chk("R4", "access low bank0", w_o, 8'h3F);
    set_w(8'h01); exec(16'h5C90, 0, 0);
    chk("R4", "access high bank15", w_o, 8'h60);
    set_w(8'h01); exec(16'h5D90, 0, 0);
    chk("R4", "banked via pointer", w_o, 8'h50);
    // R3 write back to memory, then read it back
    set_w(8'h03); exec(16'h5F10, 0, 0);
    chk("R3", "W untouched by mem dest", w_o, 8'h03);
    chk("R10", "wr addr banked", wr_addr_o, 12'h510);
    set_w(8'h00); exec(16'h5D10, 0, 0);
    chk("R3", "read back written byte", w_o, 8'h4D);

    // R9 illegal and near-miss opcodes
    exec(16'h1234, 0, 0);
    exec(16'h0900, 0, 0);
    exec(16'h5810, 0, 0);

    // R7 start while busy ignored; R11 preset while busy dropped
    set_w(8'h05); exec(16'h0820, 1, 0);
    chk("R7", "ignored start", w_o, 8'h1B);
    load_mem(16'h020, 8'h10);
    exec(16'h0800, 2, 16'h020);
    set_w(8'h01); exec(16'h5C20, 0, 0);
    chk("R11", "busy preset dropped", w_o, 8'h0F);

    // mixed run against the model
    for (int b = 0; b < 3; b++)
      for (int o = 0; o < 32; o++)
        load_mem(((b == 0) ? 0 : (b == 1) ? 3 : 15) * 256 + ((o < 16) ? o : 224 + o), $urandom_range(0, 255));
    for (int n = 0; n < 150; n++) begin
      int r;
      r = $urandom;
      if (r[20:19] == 0) load_bsr(r[18] ? 3 : 15);
      if (r[17:16] == 0) exec({8'h08, r[7:0]}, 0, 0);
      else if (r[17:16] == 3) exec({6'b010111, r[9:8], r[4] ? 4'hF : 4'h0, r[3:0]}, 0, 0);
      else exec({6'b010111, r[9:8], r[4] ? 4'hF : 4'h0, r[3:0]}, 0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule